// File: doc/BRIEF.md
# External Clock Bypass Selector

This control unit decides when the system clock tree leaves its internal oscillators and runs from an external clock. Software programs a 4-bit source-select field and a 4-bit divider step-down field. Each field uses a redundant encoding, so only the single pattern 4'b1010 turns its function on and any corrupted or partly written value leaves the clocks on internal sources. The select field only has an effect while the life-cycle controller reports that DFT is enabled. A one-bit lock register guards both fields. Software can clear the lock but cannot set it again, and once it is clear the fields keep their values.

The block drives a bypass request toward the analog clock source and watches for the matching acknowledge. A second bypass request, from the life-cycle side, also raises the request to the clock source. The life-cycle side receives its acknowledge only after the clock source has acknowledged. When DFT enable drops or the select value stops matching, the software-driven request is withdrawn and the divider step-down output falls in the next cycle.

Registers are written through a single-cycle strobe at word addresses. Address 0 is the lock register (bit 0). Address 1 is the control word, with the select field in bits [3:0] and the step-down field in bits [7:4]. Reads are combinational. All control and status pins are plain levels with no valid/ready handshake, because no data stream passes through the block.

Top module: `extclk_bypass_ctrl`

## Requirements
- R1: After reset the lock reads 1, the select and step-down fields both read 4'h5, and src_byp_req_o, lc_byp_ack_o and div_step_down_o are 0.
- R2: Writing address 0 with bit 0 = 0 clears the lock. Writing bit 0 = 1 leaves the lock unchanged, so a cleared lock stays cleared until reset.
- R3: While the lock is 0, writes to address 1 leave both fields, and therefore all outputs, unchanged.
- R4: With dft_en_i = 1, src_byp_req_o is 1 one cycle after the select field equals 4'b1010. No other select value raises it.
- R5: With dft_en_i = 0, the select field does not raise src_byp_req_o, whatever its value.
- R6: div_step_down_o is 1 one cycle after the select field and the step-down field both equal 4'b1010 with dft_en_i = 1. Every other combination gives 0.
- R7: When dft_en_i falls or the select value changes away from 4'b1010 (with no life-cycle request), src_byp_req_o and div_step_down_o return to 0 one cycle later.
- R8: lc_byp_req_i = 1 raises src_byp_req_o one cycle later, independent of dft_en_i and the fields.
- R9: lc_byp_ack_o is 1 exactly one cycle after a cycle in which lc_byp_req_i and src_byp_ack_i are both 1. Otherwise it is 0.
- R10: rd_data_o shows {7'b0, lock} at address 0, {step, select} at address 1, and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | DATA_W | Combinational read data |
| dft_en_i | input | 1 | DFT enabled by life-cycle state |
| lc_byp_req_i | input | 1 | Bypass request from life-cycle side |
| lc_byp_ack_o | output | 1 | Bypass acknowledge to life-cycle side |
| src_byp_req_o | output | 1 | Bypass request to clock source |
| src_byp_ack_i | input | 1 | Bypass acknowledge from clock source |
| div_step_down_o | output | 1 | Halve the clock dividers |

## Verification
The hardest state to reach from the ports is a cleared lock together with an armed control word. If the lock is cleared first, the fields can no longer be armed. The stimulus therefore arms the select and step-down fields while the lock is still set, then clears it, then tries to overwrite the armed values. It checks that the request and step-down outputs stay high. An exhaustive sweep of all 256 field combinations under both DFT settings, run before the lock is cleared, covers the redundant decoding.

// File: rtl/extclk_byp_pkg.sv
package extclk_byp_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam logic [FIELD_W-1:0] ARM_PAT   = 4'b1010;
  localparam logic [FIELD_W-1:0] RESET_PAT = 4'h5;
  localparam int unsigned NUM_FIELDS = 2;
  localparam int unsigned F_SEL  = 0;
  localparam int unsigned F_STEP = 1;
  localparam int unsigned LOCK_ADDR = 0;
  localparam int unsigned CTRL_ADDR = 1;
endpackage

// File: rtl/extclk_byp_regs.sv
module extclk_byp_regs
  import extclk_byp_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               lock_o,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields_o
);
  localparam int unsigned CTRL_BITS = NUM_FIELDS * FIELD_W;

  logic lock_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields_q;
  logic hit_lock, hit_ctrl;

  assign hit_lock = wr_en_i && (wr_addr_i == ADDR_W'(LOCK_ADDR));
  assign hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

  // Clear-only lock: a written zero clears it, a written one is ignored.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     lock_q <= 1'b1;
    else if (hit_lock && !wr_data_i[0]) lock_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  fields_q[g] <= RESET_PAT;
      else if (hit_ctrl && lock_q)  fields_q[g] <= wr_data_i[g*FIELD_W +: FIELD_W];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(LOCK_ADDR))      rd_data_o[0] = lock_q;
    else if (rd_addr_i == ADDR_W'(CTRL_ADDR)) rd_data_o[CTRL_BITS-1:0] = fields_q;
  end

  assign lock_o   = lock_q;
  assign fields_o = fields_q;
endmodule

// File: rtl/extclk_byp_match.sv
module extclk_byp_match
  import extclk_byp_pkg::*;
(
  input  logic [FIELD_W-1:0] value_i,
  output logic               armed_o
);
  // Redundant encoding: exactly one pattern arms the function.
  assign armed_o = (value_i == ARM_PAT);
endmodule

// File: rtl/extclk_byp_hs.sv
module extclk_byp_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_req_i,
  input  logic sw_step_i,
  input  logic lc_req_i,
  input  logic src_ack_i,
  output logic src_req_o,
  output logic lc_ack_o,
  output logic step_down_o
);
  logic src_req_q, lc_ack_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_req_q <= 1'b0;
      lc_ack_q  <= 1'b0;
      step_q    <= 1'b0;
    end else begin
      src_req_q <= sw_req_i | lc_req_i;
      lc_ack_q  <= lc_req_i & src_ack_i;
      step_q    <= sw_req_i & sw_step_i;
    end
  end

  assign src_req_o   = src_req_q;
  assign lc_ack_o    = lc_ack_q;
  assign step_down_o = step_q;
endmodule

// File: rtl/extclk_bypass_ctrl.sv
module extclk_bypass_ctrl
  import extclk_byp_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              dft_en_i,
  input  logic              lc_byp_req_i,
  output logic              lc_byp_ack_o,
  output logic              src_byp_req_o,
  input  logic              src_byp_ack_i,
  output logic              div_step_down_o
);
  logic lock_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;
  logic [NUM_FIELDS-1:0] armed;
  logic sw_req;

  extclk_byp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .lock_o(lock_q), .fields_o(fields)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_match
    extclk_byp_match u_match (.value_i(fields[g]), .armed_o(armed[g]));
  end

  assign sw_req = dft_en_i & armed[F_SEL];

  extclk_byp_hs u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sw_req_i(sw_req), .sw_step_i(armed[F_STEP]),
    .lc_req_i(lc_byp_req_i), .src_ack_i(src_byp_ack_i),
    .src_req_o(src_byp_req_o), .lc_ack_o(lc_byp_ack_o),
    .step_down_o(div_step_down_o)
  );
endmodule

// File: rtl/extclk_bypass_ctrl_chk.sv
module extclk_bypass_ctrl_chk
  import extclk_byp_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              lock_q,
  input logic [FIELD_W-1:0] sel_q,
  input logic [FIELD_W-1:0] step_q,
  input logic              dft_en_i,
  input logic              lc_byp_req_i,
  input logic              src_byp_ack_i,
  input logic              src_byp_req_o,
  input logic              lc_byp_ack_o,
  input logic              div_step_down_o
);
  // R2
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);
  // R2
  lock_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(LOCK_ADDR) && !wr_data_i[0]) |=> !lock_q);
  // R3
  ctrl_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> ($stable(sel_q) && $stable(step_q)));
  // R4
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dft_en_i && sel_q == ARM_PAT) |=> src_byp_req_o);
  // R5
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_byp_req_o |-> $past((dft_en_i && sel_q == ARM_PAT) || lc_byp_req_i));
  // R6
  step_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_step_down_o |-> $past(dft_en_i && sel_q == ARM_PAT && step_q == ARM_PAT));
  // R8
  lc_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_byp_req_i |=> src_byp_req_o);
  // R9
  lc_ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_byp_ack_o |-> $past(lc_byp_req_i && src_byp_ack_i));
endmodule

bind extclk_bypass_ctrl extclk_bypass_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .lock_q(lock_q), .sel_q(fields[0]), .step_q(fields[1]),
  .dft_en_i(dft_en_i), .lc_byp_req_i(lc_byp_req_i), .src_byp_ack_i(src_byp_ack_i),
  .src_byp_req_o(src_byp_req_o), .lc_byp_ack_o(lc_byp_ack_o),
  .div_step_down_o(div_step_down_o)
);

// File: tb/test_extclk_bypass_ctrl.sv
`timescale 1ns/1ps
module test_extclk_bypass_ctrl;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic dft_en = 1'b0;
  logic lc_req = 1'b0;
  logic lc_ack;
  logic src_req;
  logic src_ack = 1'b0;
  logic step_dn;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  extclk_bypass_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_extclk_bypass_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dft_en_i(dft_en), .lc_byp_req_i(lc_req), .lc_byp_ack_o(lc_ack),
    .src_byp_req_o(src_req), .src_byp_ack_i(src_ack),
    .div_step_down_o(step_dn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input int addr, output logic [DATA_W-1:0] data);
    rd_addr = ADDR_W'(addr);
    #1 data = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_reg(0, rd); check("R1 lock", rd, 8'h01);
    read_reg(1, rd); check("R1 fields", rd, 8'h55);
    check("R1 src_req", src_req, 0);
    check("R1 lc_ack", lc_ack, 0);
    check("R1 step", step_dn, 0);
    read_reg(2, rd); check("R10 unmapped", rd, 0);

    // R4 R5 R6 R10 exhaustive sweep of fields under both DFT states
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 16; s++) begin
        for (int t = 0; t < 16; t++) begin
          dft_en = d[0];
          write_reg(1, {t[3:0], s[3:0]});
          @(negedge clk);
          read_reg(1, rd); check("R10 ctrl readback", rd, {t[3:0], s[3:0]});
          check(d ? "R4 src_req" : "R5 src_req", src_req, (d == 1 && s == 10));
          check("R6 step", step_dn, (d == 1 && s == 10 && t == 10));
        end
      end
    end

    // R7 withdrawal on DFT drop and on select change
    write_reg(1, 8'hAA);
    @(negedge clk);
    check("R7 armed", {src_req, step_dn}, 2'b11);
    dft_en = 1'b0;
    @(negedge clk);
    check("R7 dft drop", {src_req, step_dn}, 2'b00);
    dft_en = 1'b1;
    @(negedge clk);
    check("R7 rearm", {src_req, step_dn}, 2'b11);
    write_reg(1, 8'hAB);
    @(negedge clk);
    check("R7 sel invalid", {src_req, step_dn}, 2'b00);

    // R8 R9 life-cycle request and handshake, DFT off
    dft_en = 1'b0;
    lc_req = 1'b1;
    @(negedge clk);
    check("R8 src_req from lc", src_req, 1);
    check("R9 no ack yet", lc_ack, 0);
    src_ack = 1'b1;
    @(negedge clk);
    check("R9 lc_ack", lc_ack, 1);
    check("R6 no step from lc", step_dn, 0);
    src_ack = 1'b0;
    @(negedge clk);
    check("R9 ack follows src", lc_ack, 0);
    src_ack = 1'b1;
    lc_req = 1'b0;
    @(negedge clk);
    check("R9 ack needs lc_req", lc_ack, 0);
    check("R8 release", src_req, 0);
    src_ack = 1'b0;

    // R2 R3 lock behaviour with armed fields
    dft_en = 1'b1;
    write_reg(1, 8'hAA);
    write_reg(0, 8'h01);
    read_reg(0, rd); check("R2 write one keeps lock", rd, 8'h01);
    write_reg(0, 8'hFE);
    read_reg(0, rd); check("R2 lock cleared", rd, 8'h00);
    write_reg(0, 8'h01);
    read_reg(0, rd); check("R2 lock cannot reset", rd, 8'h00);
    write_reg(1, 8'h55);
    @(negedge clk);
    read_reg(1, rd); check("R3 fields frozen", rd, 8'hAA);
    check("R3 outputs held", {src_req, step_dn}, 2'b11);
    dft_en = 1'b0;
    @(negedge clk);
    check("R5 locked dft off", src_req, 0);
    finish_run();
  end
endmodule